// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block gathers interrupt request flags from a set of peripheral sources. Each source has a flag that its own hardware event or a software write can set, and an enable bit that software controls. A source raises a request only when its flag and its enable are both set. Each source index maps to a vector slot through a parameter table. More than one source may map to the same slot, and the number of sources on each slot decides whether that slot is single or shared.

Slot 0 is the reset slot at address 0xFFFE. Slot 1 is the one non-maskable slot at 0xFFFC. Slots 2 and above are maskable, and slot k sits at address 0xFFFE − 2k. A maskable slot is pending only while the global enable input is high. The non-maskable slot ignores that input. The highest pending address wins, and the choice is made combinationally in the cycle the CPU takes the vector. The block presents the winning address together with a request line.

When the CPU acknowledges, the block clears the winning flag on the next edge if its slot has a single source. Flags behind a shared slot stay set until software clears them. After reset the reset slot is pending once. The first acknowledge retires it.

Top module: `vic_fixed_prio`

## Requirements
- R1: After reset, all flags and enables are 0, and `irq_o` is 1 with `vec_o` = 0xFFFE. An acknowledge in that state retires the reset slot, and 0xFFFE never appears again until the next reset.
- R2: A flag is set one edge after `hw_set_i` or `sw_flag_set_i` is high for its bit, and cleared one edge after `sw_flag_clr_i` is high. If a hardware set and a software clear arrive in the same cycle, the flag stays set.
- R3: Enable bits are set by `sw_en_set_i` and cleared by `sw_en_clr_i`. A source with flag 1 and enable 0 produces no request.
- R4: A source mapped to slot 1 (0xFFFC) requests regardless of `gie_i`. A source mapped to a slot of index 2 or more requests only while `gie_i` is 1.
- R5: `vec_o` equals 0xFFFE − 2·slot of the pending slot with the lowest index, which is the highest address. While `irq_o` is 0, `vec_o` is 0x0000.
- R6: Arbitration uses the pending set in the cycle `ack_i` is high. A higher-priority request that arrives after a lower one is the one taken.
- R7: When `ack_i` and `irq_o` are both high and the winning slot has one source, that source's flag is 0 after the edge, and all other flags are unchanged.
- R8: When the winning slot on an acknowledge is shared by two or more sources, no flag changes.
- R9: If a source's hardware set coincides with the acknowledge that would clear its flag, the flag remains 1.
- R10: `ack_i` while `irq_o` is 0 changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hw_set_i | input | N_SRC | Hardware event, one bit per source |
| sw_flag_set_i | input | N_SRC | Software flag set strobes |
| sw_flag_clr_i | input | N_SRC | Software flag clear strobes |
| sw_en_set_i | input | N_SRC | Software enable set strobes |
| sw_en_clr_i | input | N_SRC | Software enable clear strobes |
| gie_i | input | 1 | Global enable for maskable slots |
| ack_i | input | 1 | CPU takes the vector this cycle |
| irq_o | output | 1 | A slot is pending |
| vec_o | output | 16 | Winning vector address, or 0 when idle |
| flag_o | output | N_SRC | Current flags |
| en_o | output | N_SRC | Current enables |

## Verification
Two things can land on one flag in the same cycle: the clear that an acknowledge causes, and a new hardware event on that source. A plain software clear can likewise coincide with a hardware event. The bench drives `hw_set_i` high in the same cycle as `ack_i`, and also in the same cycle as `sw_flag_clr_i`. It then reads `flag_o` after the edge and expects it to be 1. A bound property checks that every hardware set is visible one cycle later, whatever else happens in that cycle.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int unsigned VEC_W = 16;
  localparam logic [VEC_W-1:0] VEC_TOP = 16'hFFFE;

  function automatic logic [VEC_W-1:0] slot_addr(input int unsigned slot);
    return VEC_TOP - VEC_W'(2 * slot);
  endfunction
endpackage

// File: rtl/vic_src_bank.sv
module vic_src_bank #(
  parameter int unsigned N_SRC = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] hw_set_i,
  input  logic [N_SRC-1:0] sw_flag_set_i,
  input  logic [N_SRC-1:0] sw_flag_clr_i,
  input  logic [N_SRC-1:0] sw_en_set_i,
  input  logic [N_SRC-1:0] sw_en_clr_i,
  input  logic [N_SRC-1:0] ack_clr_i,
  output logic [N_SRC-1:0] flag_o,
  output logic [N_SRC-1:0] en_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic flag_q, en_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_q <= 1'b0;
        en_q   <= 1'b0;
      end else begin
        // hardware event beats any clear
        if (hw_set_i[i] || sw_flag_set_i[i])        flag_q <= 1'b1;
        else if (sw_flag_clr_i[i] || ack_clr_i[i])  flag_q <= 1'b0;
        if (sw_en_set_i[i])                         en_q   <= 1'b1;
        else if (sw_en_clr_i[i])                    en_q   <= 1'b0;
      end
    end
    assign flag_o[i] = flag_q;
    assign en_o[i]   = en_q;
  end
endmodule

// File: rtl/vic_slot_map.sv
module vic_slot_map #(
  parameter int unsigned N_SRC  = 6,
  parameter int unsigned N_SLOT = 8
) (
  input  logic [N_SRC-1:0]              req_i,
  input  logic [N_SLOT-1:0][N_SRC-1:0]  member_i,
  input  logic                          gie_i,
  input  logic                          rst_pend_i,
  output logic [N_SLOT-1:0]             pend_o
);
  assign pend_o[0] = rst_pend_i;
  assign pend_o[1] = |(req_i & member_i[1]);
  for (genvar k = 2; k < N_SLOT; k++) begin : g_mask
    assign pend_o[k] = gie_i & (|(req_i & member_i[k]));
  end
endmodule

// File: rtl/vic_prio_pick.sv
module vic_prio_pick #(
  parameter int unsigned N_SLOT = 8,
  parameter int unsigned SLOT_W = $clog2(N_SLOT)
) (
  input  logic [N_SLOT-1:0] pend_i,
  output logic              any_o,
  output logic [SLOT_W-1:0] win_o
);
  // lowest slot index = highest address
  always_comb begin
    win_o = '0;
    for (int k = N_SLOT - 1; k >= 0; k--) begin
      if (pend_i[k]) win_o = SLOT_W'(k);
    end
  end
  assign any_o = |pend_i;
endmodule

// File: rtl/vic_fixed_prio.sv
module vic_fixed_prio
  import vic_pkg::*;
#(
  parameter int unsigned N_SRC  = 6,
  parameter int unsigned N_SLOT = 8,
  parameter int unsigned SLOT_W = $clog2(N_SLOT),
  // slot per source, source 0 in the low field; slot 0 is reserved for reset
  parameter logic [N_SRC*SLOT_W-1:0] SRC_SLOT = {3'd7, 3'd5, 3'd5, 3'd3, 3'd2, 3'd1}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] hw_set_i,
  input  logic [N_SRC-1:0] sw_flag_set_i,
  input  logic [N_SRC-1:0] sw_flag_clr_i,
  input  logic [N_SRC-1:0] sw_en_set_i,
  input  logic [N_SRC-1:0] sw_en_clr_i,
  input  logic             gie_i,
  input  logic             ack_i,
  output logic             irq_o,
  output logic [15:0]      vec_o,
  output logic [N_SRC-1:0] flag_o,
  output logic [N_SRC-1:0] en_o
);
  logic [N_SLOT-1:0][N_SRC-1:0] member;
  logic [N_SLOT-1:0]            single;
  logic [N_SLOT-1:0]            pend;
  logic [SLOT_W-1:0]            win;
  logic [N_SRC-1:0]             ack_clr;
  logic                         rst_pend_q;
  logic                         take;

  for (genvar k = 0; k < N_SLOT; k++) begin : g_slot
    for (genvar i = 0; i < N_SRC; i++) begin : g_mem
      assign member[k][i] = (SRC_SLOT[i*SLOT_W +: SLOT_W] == SLOT_W'(k));
    end
    assign single[k] = ($countones(member[k]) == 1);
  end

  vic_src_bank #(.N_SRC(N_SRC)) u_bank (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .hw_set_i      (hw_set_i),
    .sw_flag_set_i (sw_flag_set_i),
    .sw_flag_clr_i (sw_flag_clr_i),
    .sw_en_set_i   (sw_en_set_i),
    .sw_en_clr_i   (sw_en_clr_i),
    .ack_clr_i     (ack_clr),
    .flag_o        (flag_o),
    .en_o          (en_o)
  );

  vic_slot_map #(.N_SRC(N_SRC), .N_SLOT(N_SLOT)) u_map (
    .req_i      (flag_o & en_o),
    .member_i   (member),
    .gie_i      (gie_i),
    .rst_pend_i (rst_pend_q),
    .pend_o     (pend)
  );

  vic_prio_pick #(.N_SLOT(N_SLOT), .SLOT_W(SLOT_W)) u_pick (
    .pend_i (pend),
    .any_o  (irq_o),
    .win_o  (win)
  );

  assign take    = ack_i & irq_o;
  assign ack_clr = (take && single[win]) ? member[win] : '0;
  assign vec_o   = irq_o ? slot_addr(int'(win)) : 16'h0000;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        rst_pend_q <= 1'b1;
    else if (take && win == '0)         rst_pend_q <= 1'b0;
  end
endmodule

// File: rtl/vic_fixed_prio_chk.sv
module vic_fixed_prio_chk #(
  parameter int unsigned N_SRC  = 6,
  parameter int unsigned N_SLOT = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SRC-1:0] hw_set_i,
  input logic [N_SRC-1:0] sw_flag_set_i,
  input logic [N_SRC-1:0] sw_flag_clr_i,
  input logic             gie_i,
  input logic             ack_i,
  input logic             irq_o,
  input logic [15:0]      vec_o,
  input logic [N_SRC-1:0] flag_o,
  input logic [N_SRC-1:0] en_o
);
  localparam logic [15:0] VEC_LOW = 16'hFFFE - 16'(2 * (N_SLOT - 1));
  logic rst_taken_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             rst_taken_q <= 1'b0;
    else if (ack_i && vec_o == 16'hFFFE)     rst_taken_q <= 1'b1;
  end

  p_reset_once_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_taken_q |-> vec_o != 16'hFFFE);

  p_no_spurious_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && vec_o != 16'hFFFE) |-> |(flag_o & en_o));

  p_gie_mask_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gie_i && irq_o) |-> vec_o >= 16'hFFFC);

  p_vec_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> vec_o == 16'h0000);

  p_vec_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (vec_o[0] == 1'b0 && vec_o >= VEC_LOW));

  p_idle_ack_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !irq_o && sw_flag_set_i == '0 && sw_flag_clr_i == '0)
      |=> flag_o == ($past(flag_o) | $past(hw_set_i)));

  for (genvar i = 0; i < N_SRC; i++) begin : g_hw
    p_hw_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hw_set_i[i] |=> flag_o[i]);
  end
endmodule

bind vic_fixed_prio vic_fixed_prio_chk #(.N_SRC(N_SRC), .N_SLOT(N_SLOT)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .hw_set_i      (hw_set_i),
  .sw_flag_set_i (sw_flag_set_i),
  .sw_flag_clr_i (sw_flag_clr_i),
  .gie_i         (gie_i),
  .ack_i         (ack_i),
  .irq_o         (irq_o),
  .vec_o         (vec_o),
  .flag_o        (flag_o),
  .en_o          (en_o)
);

// File: tb/sim_vic_fixed_prio.sv
`timescale 1ns/1ps
module sim_vic_fixed_prio;
  localparam int N = 6;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0] hw_set = '0, fset = '0, fclr = '0, eset = '0, eclr = '0;
  logic gie = 1'b0, ack = 1'b0;
  logic irq;
  logic [15:0] vec;
  logic [N-1:0] flag, en;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  vic_fixed_prio u0 (
    .clk_i(clk), .rst_ni(rst_ni), .hw_set_i(hw_set), .sw_flag_set_i(fset),
    .sw_flag_clr_i(fclr), .sw_en_set_i(eset), .sw_en_clr_i(eclr),
    .gie_i(gie), .ack_i(ack), .irq_o(irq), .vec_o(vec), .flag_o(flag), .en_o(en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one edge, then release strobes and settle past the falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    hw_set = '0; fset = '0; fclr = '0; eset = '0; eclr = '0; ack = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    chk("R1 flags", 32'(flag), 0);
    chk("R1 enables", 32'(en), 0);
    chk("R1 irq", 32'(irq), 1);
    chk("R1 vec", 32'(vec), 32'hFFFE);
    ack = 1'b1; tick();
    chk("R1 irq after ack", 32'(irq), 0);
    chk("R5 idle vec", 32'(vec), 0);
  endtask

  task automatic t_idle_ack();
    eset = '1; fset = 6'b100000; tick();
    chk("R4 masked", 32'(irq), 0);
    ack = 1'b1; tick();
    chk("R10 flags kept", 32'(flag), 32'h20);
    fclr = '1; eclr = '1; tick();
  endtask

  task automatic t_flag_ops();
    gie = 1'b1;
    fset[1] = 1'b1; tick();
    chk("R2 sw set", 32'(flag), 32'h02);
    chk("R3 disabled", 32'(irq), 0);
    eset[1] = 1'b1; tick();
    chk("R3 enabled irq", 32'(irq), 1);
    chk("R5 vec slot2", 32'(vec), 32'hFFFA);
    hw_set[1] = 1'b1; fclr[1] = 1'b1; tick();
    chk("R2 hw beats clr", 32'(flag[1]), 1);
    fclr[1] = 1'b1; tick();
    chk("R2 sw clr", 32'(flag), 0);
    chk("R2 irq gone", 32'(irq), 0);
  endtask

  task automatic t_nmi();
    eset = '1; gie = 1'b0; hw_set = 6'b000011; tick();
    chk("R4 nmi irq", 32'(irq), 1);
    chk("R4 nmi vec", 32'(vec), 32'hFFFC);
    ack = 1'b1; tick();
    chk("R7 nmi cleared", 32'(flag), 32'h02);
    chk("R4 maskable held", 32'(irq), 0);
    gie = 1'b1; #1;
    chk("R4 gie opens", 32'(vec), 32'hFFFA);
    ack = 1'b1; tick();
    chk("R7 slot2 cleared", 32'(flag), 0);
  endtask

  task automatic t_prio();
    hw_set[5] = 1'b1; tick();
    chk("R5 lone low", 32'(vec), 32'hFFF0);
    hw_set[2] = 1'b1; hw_set[3] = 1'b1; tick();
    chk("R5 highest wins", 32'(vec), 32'hFFF8);
    fset[1] = 1'b1; tick();
    chk("R6 late higher", 32'(vec), 32'hFFFA);
    ack = 1'b1; tick();
    chk("R6 took late one", 32'(flag), 32'h2C);
    ack = 1'b1; tick();
    chk("R7 others kept", 32'(flag), 32'h28);
    chk("R5 next vec", 32'(vec), 32'hFFF4);
  endtask

  task automatic t_shared();
    fset[4] = 1'b1; tick();
    ack = 1'b1; tick();
    chk("R8 shared kept", 32'(flag), 32'h38);
    chk("R8 vec kept", 32'(vec), 32'hFFF4);
    fclr = 6'b011000; tick();
    chk("R8 sw clear", 32'(vec), 32'hFFF0);
  endtask

  task automatic t_collide();
    ack = 1'b1; hw_set[5] = 1'b1; tick();
    chk("R9 set during ack", 32'(flag), 32'h20);
    ack = 1'b1; tick();
    chk("R7 final clear", 32'(flag), 0);
    chk("R5 idle", 32'(irq), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1; #1;
    t_reset();
    t_idle_ack();
    t_flag_ops();
    t_nmi();
    t_prio();
    t_shared();
    t_collide();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule